// File: doc/BRIEF.md
# Stalling Circular Buffer Controller

This block keeps the bookkeeping for one circular region of local memory that a producing engine fills and a consuming engine drains. It holds a head pointer (the next place to write), a tail pointer (the oldest unconsumed entry) and the fill level that follows from them. Neither side has to poll the other. A producer asks for a window of free space and a consumer asks for a window of committed data. Each request is granted in the same cycle if the window fits. If it does not fit, the request is held with a stall flag until the other side's command makes room.

Each request gives an offset from its pointer and a length. Any entry inside the valid window can therefore be reached, and the same data can be read any number of times. Reading never frees space. The producer publishes data with a commit command, which moves the head. The consumer releases space with a consume command, which moves the tail. Each request and command carries a buffer tag. The block acts only on tags equal to its own identifier, so the tag is the dependency key between operations on the same memory area. The storage array itself lives outside the block, and the block supplies only wrapped slot addresses.

Top module: `cbuf_ctrl`

## Requirements
- R1: After reset the level is 0, the error flag is 0, and both pointers point to slot 0. A write of offset 0 at that point is granted at address 0.
- R2: A read request with a matching tag is granted in the same cycle exactly when offset + length <= level. Its address is (tail + offset) mod DEPTH.
- R3: A write request with a matching tag is granted in the same cycle exactly when offset + length <= DEPTH - level. Its address is (head + offset) mod DEPTH.
- R4: A matching request that does not fit raises its stall output and not its grant. It does not set the error flag.
- R5: A granted read leaves the level unchanged.
- R6: An accepted commit of n entries raises the level by n on the next cycle and moves the head by n.
- R7: An accepted consume of n entries lowers the level by n on the next cycle and moves the tail by n.
- R8: A consume of more entries than the current level is rejected. It sets the error flag and leaves the tail and the level unchanged.
- R9: A commit of more entries than the current free space is rejected. It sets the error flag and leaves the head and the level unchanged.
- R10: An accepted commit and an accepted consume in the same cycle are both applied, and the level changes by their difference. Each one is judged against the level from before that cycle.
- R11: A request, commit or consume whose tag differs from BUF_ID is ignored. It gives no grant, no stall and no change of level.
- R12: The level can reach DEPTH, and a full buffer is distinct from an empty one. When full, a read of length DEPTH is granted and a write of length 1 stalls.
- R13: The error flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req_i | input | 1 | Producer window request |
| wr_id_i | input | ID_W | Tag for the producer request and the commit |
| wr_off_i | input | AW | Offset of the write window from the head |
| wr_len_i | input | AW+1 | Length of the write window |
| wr_gnt_o | output | 1 | Write window granted |
| wr_addr_o | output | AW | Slot address of the write window start |
| wr_stall_o | output | 1 | Write request waiting for space |
| cmt_vld_i | input | 1 | Commit command |
| cmt_cnt_i | input | AW+1 | Entries to commit |
| rd_req_i | input | 1 | Consumer window request |
| rd_id_i | input | ID_W | Tag for the consumer request and the consume |
| rd_off_i | input | AW | Offset of the read window from the tail |
| rd_len_i | input | AW+1 | Length of the read window |
| rd_gnt_o | output | 1 | Read window granted |
| rd_addr_o | output | AW | Slot address of the read window start |
| rd_stall_o | output | 1 | Read request waiting for data |
| cons_vld_i | input | 1 | Consume command |
| cons_cnt_i | input | AW+1 | Entries to release |
| level_o | output | AW+1 | Committed, unconsumed entries |
| err_o | output | 1 | Sticky rejected-command flag |

## Verification
A wrong head or tail shows first in the slot addresses, in the same cycle as the next granted request. A wrong level shows both on level_o and in the grant/stall decision one cycle after the command that corrupted it. The table walks the pointers across the wrap and through the full state, so an error in the wrap bit shows as a wrong grant within one vector. A rejected command that still moves a pointer shows as a shifted read address on the next request.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_APPLY  = 2'd1,
    OP_REJECT = 2'd2
  } op_res_e;

  // window [off, off+len) lies inside the available span
  function automatic logic fits(int unsigned off, int unsigned len, int unsigned avail);
    return (off + len) <= avail;
  endfunction

  // slot address of base+off for a power-of-two ring
  function automatic int unsigned wrap_add(int unsigned base, int unsigned off,
                                           int unsigned depth);
    return (base + off) & (depth - 1);
  endfunction

  // decide what a counted command does
  function automatic op_res_e judge(logic vld, logic hit, int unsigned cnt,
                                    int unsigned avail);
    if (!(vld && hit)) return OP_IDLE;
    if (cnt > avail)   return OP_REJECT;
    return OP_APPLY;
  endfunction

endpackage

// File: rtl/cbuf_window.sv
module cbuf_window #(
  parameter int AW = 4
) (
  input  logic          req_i,
  input  logic          hit_i,
  input  logic [AW:0]   base_i,
  input  logic [AW-1:0] off_i,
  input  logic [AW:0]   len_i,
  input  logic [AW:0]   avail_i,
  output logic          gnt_o,
  output logic          stall_o,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned SLOTS = 1 << AW;

  logic fit;
  logic live;

  assign live    = req_i & hit_i;
  assign fit     = cbuf_pkg::fits(32'(off_i), 32'(len_i), 32'(avail_i));
  assign gnt_o   = live & fit;
  assign stall_o = live & ~fit;
  assign addr_o  = AW'(cbuf_pkg::wrap_add(32'(base_i), 32'(off_i), SLOTS));
endmodule

// File: rtl/cbuf_ptr.sv
module cbuf_ptr #(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step_i,
  input  logic [AW:0] cnt_i,
  output logic [AW:0] ptr_o
);
  // the extra top bit is the lap bit that separates full from empty
  always_ff @(posedge clk) begin
    if (!rst_n)      ptr_o <= '0;
    else if (step_i) ptr_o <= ptr_o + cnt_i;
  end
endmodule

// File: rtl/cbuf_ctrl.sv
module cbuf_ctrl #(
  parameter int DEPTH  = 16,
  parameter int ID_W   = 4,
  parameter int BUF_ID = 3,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_req_i,
  input  logic [ID_W-1:0] wr_id_i,
  input  logic [AW-1:0]   wr_off_i,
  input  logic [CW-1:0]   wr_len_i,
  output logic            wr_gnt_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic            wr_stall_o,
  input  logic            cmt_vld_i,
  input  logic [CW-1:0]   cmt_cnt_i,
  input  logic            rd_req_i,
  input  logic [ID_W-1:0] rd_id_i,
  input  logic [AW-1:0]   rd_off_i,
  input  logic [CW-1:0]   rd_len_i,
  output logic            rd_gnt_o,
  output logic [AW-1:0]   rd_addr_o,
  output logic            rd_stall_o,
  input  logic            cons_vld_i,
  input  logic [CW-1:0]   cons_cnt_i,
  output logic [CW-1:0]   level_o,
  output logic            err_o
);
  import cbuf_pkg::*;

  localparam logic [ID_W-1:0] MY_TAG = ID_W'(BUF_ID);
  localparam logic [CW-1:0]   FULL   = CW'(DEPTH);

  logic [CW-1:0] head, tail, level, room;
  logic          wr_hit, rd_hit;
  op_res_e       cmt_res, cons_res;

  // named events for the checker
  logic cmt_ok, cmt_bad, cons_ok, cons_bad;

  assign wr_hit = (wr_id_i == MY_TAG);
  assign rd_hit = (rd_id_i == MY_TAG);
  assign level  = head - tail;
  assign room   = FULL - level;

  assign cmt_res  = judge(cmt_vld_i,  wr_hit, 32'(cmt_cnt_i),  32'(room));
  assign cons_res = judge(cons_vld_i, rd_hit, 32'(cons_cnt_i), 32'(level));

  assign cmt_ok   = (cmt_res  == OP_APPLY);
  assign cmt_bad  = (cmt_res  == OP_REJECT);
  assign cons_ok  = (cons_res == OP_APPLY);
  assign cons_bad = (cons_res == OP_REJECT);

  cbuf_ptr #(.AW(AW)) u_head (
    .clk(clk), .rst_n(rst_n), .step_i(cmt_ok), .cnt_i(cmt_cnt_i), .ptr_o(head)
  );

  cbuf_ptr #(.AW(AW)) u_tail (
    .clk(clk), .rst_n(rst_n), .step_i(cons_ok), .cnt_i(cons_cnt_i), .ptr_o(tail)
  );

  cbuf_window #(.AW(AW)) u_wr_win (
    .req_i(wr_req_i), .hit_i(wr_hit), .base_i(head), .off_i(wr_off_i),
    .len_i(wr_len_i), .avail_i(room), .gnt_o(wr_gnt_o), .stall_o(wr_stall_o),
    .addr_o(wr_addr_o)
  );

  cbuf_window #(.AW(AW)) u_rd_win (
    .req_i(rd_req_i), .hit_i(rd_hit), .base_i(tail), .off_i(rd_off_i),
    .len_i(rd_len_i), .avail_i(level), .gnt_o(rd_gnt_o), .stall_o(rd_stall_o),
    .addr_o(rd_addr_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                    err_o <= 1'b0;
    else if (cmt_bad || cons_bad)  err_o <= 1'b1;
  end

  assign level_o = level;
endmodule

// File: rtl/cbuf_ctrl_chk.sv
module cbuf_ctrl_chk #(
  parameter int DEPTH  = 16,
  parameter int ID_W   = 4,
  parameter int BUF_ID = 3,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_req_i,
  input logic [ID_W-1:0] rd_id_i,
  input logic [AW-1:0]   rd_off_i,
  input logic [CW-1:0]   rd_len_i,
  input logic            rd_gnt_o,
  input logic            rd_stall_o,
  input logic            wr_gnt_o,
  input logic            wr_stall_o,
  input logic [CW-1:0]   cmt_cnt_i,
  input logic [CW-1:0]   cons_cnt_i,
  input logic [CW-1:0]   level_o,
  input logic            err_o,
  input logic            cmt_ok,
  input logic            cmt_bad,
  input logic            cons_ok,
  input logic            cons_bad
);
  AST_RD_GNT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_gnt_o |-> (32'(rd_off_i) + 32'(rd_len_i)) <= 32'(level_o)); // R2

  AST_STALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_gnt_o && rd_stall_o) && !(wr_gnt_o && wr_stall_o)); // R4

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level_o) <= DEPTH); // R12

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o); // R13

  AST_CONS_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_bad && !cmt_ok) |=> ($stable(level_o) && err_o)); // R8

  AST_CMT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_bad && !cons_ok) |=> ($stable(level_o) && err_o)); // R9

  AST_NET_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_ok && cons_ok) |=>
      level_o == CW'($past(level_o) + $past(cmt_cnt_i) - $past(cons_cnt_i))); // R10

  AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && rd_id_i != ID_W'(BUF_ID)) |-> (!rd_gnt_o && !rd_stall_o)); // R11
endmodule

bind cbuf_ctrl cbuf_ctrl_chk #(.DEPTH(DEPTH), .ID_W(ID_W), .BUF_ID(BUF_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req_i(rd_req_i), .rd_id_i(rd_id_i),
  .rd_off_i(rd_off_i), .rd_len_i(rd_len_i), .rd_gnt_o(rd_gnt_o),
  .rd_stall_o(rd_stall_o), .wr_gnt_o(wr_gnt_o), .wr_stall_o(wr_stall_o),
  .cmt_cnt_i(cmt_cnt_i), .cons_cnt_i(cons_cnt_i), .level_o(level_o),
  .err_o(err_o), .cmt_ok(cmt_ok), .cmt_bad(cmt_bad), .cons_ok(cons_ok),
  .cons_bad(cons_bad)
);

// File: tb/cbuf_ctrl_bench.sv
module cbuf_ctrl_bench;
  localparam int DEPTH = 16;
  localparam int ID_W  = 4;
  localparam int MYID  = 3;
  localparam int AW    = 4;
  localparam int CW    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic            wr_req, rd_req, cmt_vld, cons_vld;
  logic [ID_W-1:0] wr_id, rd_id;
  logic [AW-1:0]   wr_off, rd_off, wr_addr, rd_addr;
  logic [CW-1:0]   wr_len, rd_len, cmt_cnt, cons_cnt, level;
  logic            wr_gnt, wr_stall, rd_gnt, rd_stall, err;

  cbuf_ctrl #(.DEPTH(DEPTH), .ID_W(ID_W), .BUF_ID(MYID)) u_cbuf_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_req_i(wr_req), .wr_id_i(wr_id), .wr_off_i(wr_off), .wr_len_i(wr_len),
    .wr_gnt_o(wr_gnt), .wr_addr_o(wr_addr), .wr_stall_o(wr_stall),
    .cmt_vld_i(cmt_vld), .cmt_cnt_i(cmt_cnt),
    .rd_req_i(rd_req), .rd_id_i(rd_id), .rd_off_i(rd_off), .rd_len_i(rd_len),
    .rd_gnt_o(rd_gnt), .rd_addr_o(rd_addr), .rd_stall_o(rd_stall),
    .cons_vld_i(cons_vld), .cons_cnt_i(cons_cnt),
    .level_o(level), .err_o(err)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [CW-1:0] cmt;
    logic [CW-1:0] cons;
    logic [AW-1:0] roff;
    logic [CW-1:0] rlen;
    logic [AW-1:0] woff;
    logic [CW-1:0] wlen;
    logic          e_rg;
    logic [AW-1:0] e_ra;
    logic          e_wg;
    logic [AW-1:0] e_wa;
    logic [CW-1:0] e_lvl;
  } vec_t;

  // cmt cons roff rlen woff wlen | rgnt raddr wgnt waddr level_after
  localparam vec_t VEC [6] = '{
    '{5'd5, 5'd0,  4'd0,  5'd1,  4'd0, 5'd4,  1'b0, 4'd0, 1'b1, 4'd0,  5'd5},
    '{5'd0, 5'd0,  4'd2,  5'd3,  4'd10,5'd2,  1'b1, 4'd2, 1'b0, 4'd0,  5'd5},
    '{5'd8, 5'd3,  4'd4,  5'd2,  4'd9, 5'd2,  1'b0, 4'd0, 1'b1, 4'd14, 5'd10},
    '{5'd6, 5'd0,  4'd0,  5'd10, 4'd0, 5'd1,  1'b1, 4'd3, 1'b1, 4'd13, 5'd16},
    '{5'd0, 5'd16, 4'd15, 5'd1,  4'd0, 5'd1,  1'b1, 4'd2, 1'b0, 4'd0,  5'd0},
    '{5'd0, 5'd0,  4'd0,  5'd1,  4'd0, 5'd16, 1'b0, 4'd0, 1'b1, 4'd3,  5'd0}
  };

  task automatic idle();
    wr_req = 0; rd_req = 0; cmt_vld = 0; cons_vld = 0;
    wr_id = MYID[ID_W-1:0]; rd_id = MYID[ID_W-1:0];
    wr_off = 0; rd_off = 0; wr_len = 0; rd_len = 0; cmt_cnt = 0; cons_cnt = 0;
  endtask

  // apply commands for one cycle, then check the level the cycle after
  task automatic pulse(input bit c, input int cc, input bit s, input int sc,
                       input int ctag, input int stag);
    @(negedge clk);
    cmt_vld = c; cmt_cnt = CW'(cc); wr_id = ID_W'(ctag);
    cons_vld = s; cons_cnt = CW'(sc); rd_id = ID_W'(stag);
    @(posedge clk); #1 idle();
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(level == 0, "R1 level after reset", int'(level), 0);
    chk(err == 0, "R1 err after reset", int'(err), 0);

    // table walk
    foreach (VEC[i]) begin
      @(negedge clk);
      cmt_vld = (VEC[i].cmt != 0); cmt_cnt = VEC[i].cmt;
      cons_vld = (VEC[i].cons != 0); cons_cnt = VEC[i].cons;
      rd_req = 1; rd_off = VEC[i].roff; rd_len = VEC[i].rlen;
      wr_req = 1; wr_off = VEC[i].woff; wr_len = VEC[i].wlen;
      #2;
      chk(rd_gnt == VEC[i].e_rg, "R2 read grant", int'(rd_gnt), int'(VEC[i].e_rg));
      chk(rd_stall == !VEC[i].e_rg, "R4 read stall", int'(rd_stall), int'(!VEC[i].e_rg));
      chk(wr_gnt == VEC[i].e_wg, "R3 write grant", int'(wr_gnt), int'(VEC[i].e_wg));
      chk(wr_stall == !VEC[i].e_wg, "R4 write stall", int'(wr_stall), int'(!VEC[i].e_wg));
      if (VEC[i].e_rg)
        chk(rd_addr == VEC[i].e_ra, "R2 read addr", int'(rd_addr), int'(VEC[i].e_ra));
      if (VEC[i].e_wg)
        chk(wr_addr == VEC[i].e_wa, "R3 write addr", int'(wr_addr), int'(VEC[i].e_wa));
      @(posedge clk); #1 idle();
      @(negedge clk);
      // vectors 1 (read only, R5), 2 (both, R10), 3 (R6), 4 (R7, R12)
      chk(level == VEC[i].e_lvl, "R5 R6 R7 R10 R12 level", int'(level), int'(VEC[i].e_lvl));
      chk(err == 0, "R4 no error on stall", int'(err), 0);
    end

    // R9: commit beyond free space
    pulse(1, 17, 0, 0, MYID, MYID);
    @(negedge clk);
    chk(err == 1, "R9 err on over-commit", int'(err), 1);
    chk(level == 0, "R9 level kept", int'(level), 0);
    pulse(0, 0, 0, 0, MYID, MYID);
    @(negedge clk);
    chk(err == 1, "R13 err sticky", int'(err), 1);

    // R1: reset clears and rewinds
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(err == 0, "R1 err cleared", int'(err), 0);
    wr_req = 1; wr_off = 0; wr_len = 1; #2;
    chk(wr_gnt == 1 && wr_addr == 0, "R1 write at slot 0", int'(wr_addr), 0);
    idle();

    // R8: over-consume rejected, tail unchanged
    pulse(0, 0, 1, 1, MYID, MYID);
    @(negedge clk);
    chk(err == 1, "R8 err on over-consume", int'(err), 1);
    chk(level == 0, "R8 level kept", int'(level), 0);
    pulse(1, 2, 0, 0, MYID, MYID);
    @(negedge clk);
    rd_req = 1; rd_off = 0; rd_len = 1; #2;
    chk(rd_gnt == 1 && rd_addr == 0, "R8 tail not moved", int'(rd_addr), 0);
    idle();

    // R11: foreign tag ignored
    @(negedge clk);
    rd_req = 1; rd_id = 5; rd_off = 0; rd_len = 1;
    wr_req = 1; wr_id = 5; wr_off = 0; wr_len = 1; #2;
    chk(!rd_gnt && !rd_stall, "R11 foreign read quiet", int'(rd_gnt | rd_stall), 0);
    chk(!wr_gnt && !wr_stall, "R11 foreign write quiet", int'(wr_gnt | wr_stall), 0);
    idle();
    pulse(1, 4, 1, 1, 5, 5);
    @(negedge clk);
    chk(level == 2, "R11 foreign commands no effect", int'(level), 2);

    // R12: fill to the brim
    pulse(1, 14, 0, 0, MYID, MYID);
    @(negedge clk);
    chk(level == 16, "R12 level full", int'(level), 16);
    rd_req = 1; rd_off = 0; rd_len = 16; wr_req = 1; wr_off = 0; wr_len = 1; #2;
    chk(rd_gnt == 1, "R12 full read granted", int'(rd_gnt), 1);
    chk(wr_stall == 1 && wr_gnt == 0, "R12 full write stalls", int'(wr_stall), 1);
    idle();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule